// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block holds the digital half of a dual-slope integrating analog-to-digital converter. It drives three switch controls: discharge of the integrator, connection of the unknown input, and connection of the reference. It counts system clocks and watches a one-bit zero-crossing comparator. A start request first empties the integrator for a fixed number of clocks. The input is then integrated for a fixed window whose length in clocks is a parameter, so it can be set to a whole number of mains periods and the mains frequency and its harmonics fall into nulls of the averaging response. The reference is then integrated until the comparator reports that the integrator has returned to zero.

The conversion result is the number of reference-phase clocks counted before the crossing. Since both ramps use the same integrator, the ratio of the two intervals does not depend on its time constant, so the block keeps no calibration state. The caller must hold the analog input steady from start until done. The longest conversion is one full input window plus a reference phase of 2^N clocks, where N is the result width. If no crossing occurs within that limit, the result saturates and an over-range flag is raised.

Top module: `dual_slope_ctrl`

## Requirements
- R1: While reset is high, and in the cycle after reset ends, busy, done, over_range, result and all three switch controls are zero.
- R2: When start is high in a clock where busy is low, busy and discharge go high at the next edge. Discharge then stays high for exactly DISCH_CLKS cycles.
- R3: Input integration (sel_input high) starts in the cycle right after discharge ends and lasts exactly T1_CLKS cycles.
- R4: Reference integration (sel_ref high) starts in the cycle right after input integration ends. In each reference cycle the block samples zero_cross at the closing edge. If that cycle was reference cycle k (counting from 0) and zero_cross is high, the result is k, so sel_ref stays high for k+1 cycles.
- R5: At most one of discharge, sel_input and sel_ref is high in any cycle. None of them is high while busy is low.
- R6: If zero_cross is not seen high in any of the 2^CNT_W reference cycles, the result is all ones and over_range is 1. When a crossing is seen, over_range is 0.
- R7: done is high for exactly one cycle per accepted start. done rises at the same edge where busy falls and result and over_range take their new values.
- R8: result and over_range keep their values in every cycle between two done pulses.
- R9: start while busy is high is ignored: the running conversion continues unchanged, and no extra conversion or done pulse follows.
- R10: zero_cross has no effect outside the reference phase. A comparator that is already high during discharge and input integration does not shorten either phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Conversion request, accepted only while idle |
| zero_cross | input | 1 | Comparator: high when the integrator is at or below zero |
| busy | output | 1 | Conversion in progress |
| discharge | output | 1 | Closes the integrator discharge switch |
| sel_input | output | 1 | Connects the input to the integrator |
| sel_ref | output | 1 | Connects the reference to the integrator |
| result | output | CNT_W | Reference-phase count of the last conversion |
| over_range | output | 1 | Last conversion saturated without a crossing |
| done | output | 1 | One-cycle completion strobe |

## Verification
The edge that accepts start counts as edge one. done rises DISCH_CLKS + T1_CLKS + R + 1 edges after the sample where start was driven, where R is the number of reference cycles: the ceiling of T1_CLKS·vin/vref plus one, or 2^CNT_W on over-range. The driver stamps every expected item with the cycle in which it raised start. The monitor samples on the falling clock edge, so each output is read half a cycle after the edge that set it. When done appears, the monitor compares the elapsed cycles, the result, the flag and the lengths of the three switch phases with the stamped item. A simple integer integrator model, stepped on the same edges as the design, supplies zero_cross.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DISCH,
        ST_INTEG,
        ST_DEINT
    } dsadc_state_e;

    // switch controls presented to the analog front end
    typedef struct packed {
        logic discharge;
        logic sel_input;
        logic sel_ref;
    } dsadc_sw_t;

    // completion event raised by the sequencer
    typedef struct packed {
        logic valid;
        logic ovf;
    } dsadc_fin_t;

    function automatic int unsigned imax(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic dsadc_sw_t sw_for(dsadc_state_e s);
        dsadc_sw_t sw;
        sw = '0;
        case (s)
            ST_DISCH: sw.discharge = 1'b1;
            ST_INTEG: sw.sel_input = 1'b1;
            ST_DEINT: sw.sel_ref   = 1'b1;
            default:  sw = '0;
        endcase
        return sw;
    endfunction

endpackage

// File: rtl/dsadc_counter.sv
module dsadc_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq
    import dsadc_pkg::*;
#(
    parameter int CW         = 10,
    parameter int CNT_W      = 10,
    parameter int T1_CLKS    = 1024,
    parameter int DISCH_CLKS = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic           zero_cross,
    input  logic [CW-1:0]  cnt,
    output dsadc_state_e   state,
    output logic           cnt_clr,
    output logic           cnt_en,
    output dsadc_fin_t     fin
);

    localparam logic [CW-1:0] DISCH_LAST = CW'(DISCH_CLKS - 1);
    localparam logic [CW-1:0] T1_LAST    = CW'(T1_CLKS - 1);
    localparam logic [CW-1:0] DEINT_LAST = CW'((1 << CNT_W) - 1);

    dsadc_state_e state_nx;

    always_comb begin
        state_nx = state;
        cnt_clr  = 1'b0;
        cnt_en   = 1'b0;
        fin      = '0;
        case (state)
            ST_IDLE: begin
                if (start) begin
                    state_nx = ST_DISCH;
                    cnt_clr  = 1'b1;
                end
            end
            ST_DISCH: begin
                if (cnt == DISCH_LAST) begin
                    state_nx = ST_INTEG;
                    cnt_clr  = 1'b1;
                end else begin
                    cnt_en = 1'b1;
                end
            end
            ST_INTEG: begin
                if (cnt == T1_LAST) begin
                    state_nx = ST_DEINT;
                    cnt_clr  = 1'b1;
                end else begin
                    cnt_en = 1'b1;
                end
            end
            ST_DEINT: begin
                if (zero_cross) begin
                    fin.valid = 1'b1;
                    state_nx  = ST_IDLE;
                end else if (cnt == DEINT_LAST) begin
                    fin.valid = 1'b1;
                    fin.ovf   = 1'b1;
                    state_nx  = ST_IDLE;
                end else begin
                    cnt_en = 1'b1;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

endmodule

// File: rtl/dsadc_result.sv
module dsadc_result
    import dsadc_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  dsadc_fin_t       fin,
    input  logic [CNT_W-1:0] cnt_low,
    output logic [CNT_W-1:0] result,
    output logic             over_range,
    output logic             done
);

    always_ff @(posedge clk) begin
        if (rst) begin
            result     <= '0;
            over_range <= 1'b0;
            done       <= 1'b0;
        end else begin
            done <= fin.valid;
            if (fin.valid) begin
                result     <= fin.ovf ? '1 : cnt_low;
                over_range <= fin.ovf;
            end
        end
    end

endmodule

// File: rtl/dual_slope_ctrl.sv
module dual_slope_ctrl
    import dsadc_pkg::*;
#(
    parameter int CNT_W      = 10,
    parameter int T1_CLKS    = 1024,
    parameter int DISCH_CLKS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             zero_cross,
    output logic             busy,
    output logic             discharge,
    output logic             sel_input,
    output logic             sel_ref,
    output logic [CNT_W-1:0] result,
    output logic             over_range,
    output logic             done
);

    localparam int CW = int'(imax(CNT_W, imax($clog2(T1_CLKS), $clog2(DISCH_CLKS))));

    dsadc_state_e    state;
    dsadc_fin_t      fin;
    dsadc_sw_t       sw;
    logic [CW-1:0]   cnt;
    logic            cnt_clr;
    logic            cnt_en;

    dsadc_counter #(.W(CW)) u_cnt (
        .clk (clk),
        .rst (rst),
        .clr (cnt_clr),
        .en  (cnt_en),
        .cnt (cnt)
    );

    dsadc_seq #(
        .CW         (CW),
        .CNT_W      (CNT_W),
        .T1_CLKS    (T1_CLKS),
        .DISCH_CLKS (DISCH_CLKS)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .zero_cross (zero_cross),
        .cnt        (cnt),
        .state      (state),
        .cnt_clr    (cnt_clr),
        .cnt_en     (cnt_en),
        .fin        (fin)
    );

    dsadc_result #(.CNT_W(CNT_W)) u_res (
        .clk        (clk),
        .rst        (rst),
        .fin        (fin),
        .cnt_low    (cnt[CNT_W-1:0]),
        .result     (result),
        .over_range (over_range),
        .done       (done)
    );

    assign sw        = sw_for(state);
    assign busy      = (state != ST_IDLE);
    assign discharge = sw.discharge;
    assign sel_input = sw.sel_input;
    assign sel_ref   = sw.sel_ref;

endmodule

// File: rtl/dsadc_checker.sv
module dsadc_checker #(
    parameter int CNT_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic             discharge,
    input logic             sel_input,
    input logic             sel_ref,
    input logic [CNT_W-1:0] result,
    input logic             over_range,
    input logic             done
);

    a_r5_one_switch: assert property (@(posedge clk) disable iff (rst)
        $onehot0({discharge, sel_input, sel_ref}));

    a_r5_idle_open: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !(discharge || sel_input || sel_ref));

    a_r2_start_accept: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && discharge));

    a_r3_after_discharge: assert property (@(posedge clk) disable iff (rst)
        $rose(sel_input) |-> $past(discharge));

    a_r4_after_input: assert property (@(posedge clk) disable iff (rst)
        $rose(sel_ref) |-> $past(sel_input));

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r7_done_with_idle: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    a_r6_saturate: assert property (@(posedge clk) disable iff (rst)
        over_range |-> (result == {CNT_W{1'b1}}));

    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(result) && $stable(over_range)));

endmodule

bind dual_slope_ctrl dsadc_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .busy       (busy),
    .discharge  (discharge),
    .sel_input  (sel_input),
    .sel_ref    (sel_ref),
    .result     (result),
    .over_range (over_range),
    .done       (done)
);

// File: tb/dual_slope_ctrl_tb.sv
module dual_slope_ctrl_tb;

    localparam int CNT_W  = 6;
    localparam int T1     = 48;
    localparam int DISCH  = 3;
    localparam int VREF   = 20;
    localparam int FULL   = 1 << CNT_W;
    localparam int WD_LIM = 150000;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic             zero_cross;
    logic             busy, discharge, sel_input, sel_ref, over_range, done;
    logic [CNT_W-1:0] result;

    int vin   = 0;
    int integ = 0;
    int cyc   = 0;
    int checks = 0;
    int errors = 0;

    typedef struct {
        int res;
        bit ovf;
        int refc;
        int t0;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    dual_slope_ctrl #(
        .CNT_W      (CNT_W),
        .T1_CLKS    (T1),
        .DISCH_CLKS (DISCH)
    ) u_dut (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .zero_cross (zero_cross),
        .busy       (busy),
        .discharge  (discharge),
        .sel_input  (sel_input),
        .sel_ref    (sel_ref),
        .result     (result),
        .over_range (over_range),
        .done       (done)
    );

    // integer model of the analog integrator and comparator
    always_ff @(posedge clk) begin
        if (discharge)      integ <= 0;
        else if (sel_input) integ <= integ + vin;
        else if (sel_ref)   integ <= integ - VREF;
    end
    assign zero_cross = (integ <= 0);

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d (cycle %0d)", tag, got, exp, cyc);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // watchdog
    always @(posedge clk) begin
        if (cyc == WD_LIM) begin
            errors++;
            $display("FAIL watchdog: got %0d expected %0d", cyc, WD_LIM);
            summary();
        end
    end

    // monitor: phase lengths, hold, and scoreboard comparison
    int  n_dis = 0, n_in = 0, n_ref = 0, n_done = 0;
    int  last_res = 0;
    bit  last_ovf = 1'b0;
    bit  hold_bad = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (discharge) n_dis++;
            if (sel_input) n_in++;
            if (sel_ref)   n_ref++;
            if (done) begin
                n_done++;
                if (sb.size() == 0) begin
                    chk("R7 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk("R4 result", int'(result), e.res);
                    chk("R6 over_range", int'(over_range), int'(e.ovf));
                    chk("R2 discharge length", n_dis, DISCH);
                    chk("R3 R10 input length", n_in, T1);
                    chk("R4 reference length", n_ref, e.refc);
                    chk("R7 latency", cyc - e.t0, 1 + DISCH + T1 + e.refc);
                    chk("R7 busy low at done", int'(busy), 0);
                    chk("R8 hold before done", int'(hold_bad), 0);
                end
                n_dis = 0; n_in = 0; n_ref = 0;
                last_res = int'(result);
                last_ovf = over_range;
                hold_bad = 1'b0;
            end else if (int'(result) != last_res || over_range != last_ovf) begin
                hold_bad = 1'b1;
            end
        end
    end

    task automatic convert(int x, bit poke);
        exp_t e;
        int   c;
        while (busy) @(negedge clk);
        vin = x;
        c = (T1 * x + VREF - 1) / VREF;
        if (c >= FULL) begin
            e.res = FULL - 1; e.ovf = 1'b1; e.refc = FULL;
        end else begin
            e.res = c; e.ovf = 1'b0; e.refc = c + 1;
        end
        e.t0 = cyc;
        sb.push_back(e);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (DISCH + 5) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk("R9 still busy", int'(busy), 1);
            chk("R9 still in input phase", int'(sel_input), 1);
        end
        while (sb.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R7 done single pulse", int'(done), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk("R1 busy in reset", int'(busy), 0);
        chk("R1 switches in reset", int'({discharge, sel_input, sel_ref}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 result", int'(result), 0);
        chk("R1 over_range", int'(over_range), 0);
        chk("R5 switches idle", int'({discharge, sel_input, sel_ref}), 0);

        convert(0, 1'b0);    // R10: comparator high from the start, R4 result 0
        convert(1, 1'b0);    // 2.4 -> 3
        convert(5, 1'b0);    // 12
        convert(13, 1'b0);   // 31.2 -> 32
        convert(26, 1'b0);   // 62.4 -> 63, largest non-saturated
        convert(27, 1'b0);   // R6: 64.8 -> saturate
        convert(100, 1'b0);  // R6: far over range
        convert(10, 1'b0);   // over_range clears: 24
        convert(7, 1'b1);    // R9: extra start during input phase, 16.8 -> 17

        repeat (20) @(negedge clk);
        chk("R9 done count", n_done, 9);
        chk("R8 held after last done", int'(result), 17);
        chk("R5 switches idle at end", int'({discharge, sel_input, sel_ref}), 0);
        summary();
    end

endmodule